// File: doc/BRIEF.md
# Serial Clock Enable Register

This block switches each of twelve clock outputs on or off one at a time. A two-wire serial port (a shift clock and a data line) loads a twelve-bit enable word. Every output owns a small resynchronizer that runs on that output's own clock. An output therefore stops or restarts only while its raw clock is low, and every pulse it emits is a complete high phase of the raw clock.

Typical use sits just behind a bank of clock dividers. Board logic or a management controller shifts in a word to park unused clock loads. While the active-low master reset is asserted, all outputs are held low. When reset is released, every enable bit is set, so all outputs run until the serial port turns some of them off.

Top module: `serial_clk_enable`

## Requirements
- R1: On each rising edge of `sclk_i`, `sdata_i` enters enable bit 0 and every bit k moves to bit k+1. After twelve shifts, the first bit shifted in sits at bit 11.
- R2: Enable bit i controls `clk_gated_o[i]`, so bit 0 drives output 0 and bit 11 drives output 11. A value of 1 lets the clock run and 0 stops it.
- R3: While `rst_ni` is low, every output is held low and the enable word is forced to all ones.
- R4: After `rst_ni` rises, all twelve outputs run, starting within two falling edges of their own raw clocks.
- R5: If an enable bit has been 0 at two consecutive falling edges of its raw clock, that output shows no high level until the bit returns to 1.
- R6: If an enable bit has been 1 at two consecutive falling edges of its raw clock, the output follows the raw clock during the next high phase.
- R7: Outside reset, every high pulse on a gated output lasts exactly one full high phase of its raw clock, and a stopped output rests low.
- R8: Changing one enable bit leaves the activity and pulse shape of every other output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous master reset |
| sclk_i | input | 1 | Serial shift clock, rising-edge active |
| sdata_i | input | 1 | Serial enable data |
| clk_raw_i | input | N_OUT | Free-running clocks, one per output |
| clk_gated_o | output | N_OUT | Gated clocks; bit i freezes low when disabled |

## Verification
The bench builds the block with its default parameters: twelve outputs, each with a two-stage resynchronizer. Each raw clock gets its own unrelated period, and the shift-clock edges fall half a nanosecond away from every raw edge. This exercises each output's freeze path against an asynchronous enable. The two-stage depth makes the latency bound of two raw cycles directly observable. The full word width allows single-bit, end-bit, alternating and partial-shift patterns, and lets the bench measure the pulse width of every output separately.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int unsigned DEF_OUTS  = 12;
  localparam int unsigned DEF_SYNC  = 2;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/sce_shift_reg.sv
module sce_shift_reg #(
  parameter int unsigned WIDTH = sce_pkg::DEF_OUTS
) (
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  output logic [WIDTH-1:0] en_o
);
  logic [WIDTH-1:0] sh_q;

  // reset presets to all-ones: every output runs until software disables it
  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[WIDTH-2:0], sdata_i};
  end

  assign en_o = sh_q;
endmodule

// File: rtl/sce_sync_gate.sv
module sce_sync_gate #(
  parameter int unsigned STAGES = sce_pkg::DEF_SYNC
) (
  input  logic rst_ni,
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  logic [STAGES-1:0] sync_q;

  // falling-edge stages: enable only moves while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], en_i};
  end

  assign clk_o = clk_i & sync_q[STAGES-1];
endmodule

// File: rtl/serial_clk_enable.sv
module serial_clk_enable #(
  parameter int unsigned N_OUT  = sce_pkg::DEF_OUTS,
  parameter int unsigned STAGES = sce_pkg::DEF_SYNC
) (
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic [N_OUT-1:0] clk_raw_i,
  output logic [N_OUT-1:0] clk_gated_o
);
  localparam int unsigned IDX_W = sce_pkg::clog2_min1(N_OUT);

  logic [N_OUT-1:0] en_q;

  sce_shift_reg #(.WIDTH(N_OUT)) u_shift (
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .sdata_i (sdata_i),
    .en_o    (en_q)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    localparam logic [IDX_W-1:0] IDX = IDX_W'(g);
    sce_sync_gate #(.STAGES(STAGES)) u_gate (
      .rst_ni (rst_ni),
      .clk_i  (clk_raw_i[IDX]),
      .en_i   (en_q[IDX]),
      .clk_o  (clk_gated_o[IDX])
    );
  end
endmodule

// File: rtl/serial_clk_enable_chk.sv
module serial_clk_enable_chk #(
  parameter int unsigned N_OUT = sce_pkg::DEF_OUTS
) (
  input logic             rst_ni,
  input logic             sclk_i,
  input logic             sdata_i,
  input logic [N_OUT-1:0] clk_raw_i,
  input logic [N_OUT-1:0] clk_gated_o,
  input logic [N_OUT-1:0] en_q
);
  assert_shift_R1: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    1'b1 |=> (en_q == {$past(en_q[N_OUT-2:0]), $past(sdata_i)}));

  for (genvar g = 0; g < N_OUT; g++) begin : g_chk
    logic [1:0] off_cnt, on_cnt;

    always_ff @(negedge clk_raw_i[g] or negedge rst_ni) begin
      if (!rst_ni) begin
        off_cnt <= '0;
        on_cnt  <= '0;
      end else begin
        off_cnt <= en_q[g] ? 2'd0 : ((off_cnt == 2'd3) ? off_cnt : off_cnt + 2'd1);
        on_cnt  <= !en_q[g] ? 2'd0 : ((on_cnt == 2'd3) ? on_cnt : on_cnt + 2'd1);
      end
    end

    assert_reset_low_R3: assert property (@(negedge clk_raw_i[g])
      !rst_ni |-> !clk_gated_o[g]);

    assert_reset_preset_R3: assert property (@(posedge clk_raw_i[g])
      !rst_ni |-> en_q[g]);

    assert_stop_R5: assert property (@(negedge clk_raw_i[g]) disable iff (!rst_ni)
      (off_cnt >= 2'd2) |-> !clk_gated_o[g]);

    assert_run_R6: assert property (@(negedge clk_raw_i[g]) disable iff (!rst_ni)
      (on_cnt >= 2'd2) |-> clk_gated_o[g]);
  end
endmodule

bind serial_clk_enable serial_clk_enable_chk #(.N_OUT(N_OUT)) u_chk (
  .rst_ni      (rst_ni),
  .sclk_i      (sclk_i),
  .sdata_i     (sdata_i),
  .clk_raw_i   (clk_raw_i),
  .clk_gated_o (clk_gated_o),
  .en_q        (en_q)
);

// File: tb/serial_clk_enable_tb.sv
`timescale 1ns/100ps
module serial_clk_enable_tb;
  localparam int  N = 12;
  localparam real SCLK_PERIOD = 20.0;
  localparam real SETTLE = 84.0;   // three periods of the slowest raw clock
  localparam real WINDOW = 140.0;

  typedef struct { logic [N-1:0] v; string tag; } item_t;

  logic rst_ni, sclk_i, sdata_i;
  logic [N-1:0] clk_raw, gated;
  int pcnt[N];
  int pbad[N];

  serial_clk_enable u_dut (
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .sdata_i     (sdata_i),
    .clk_raw_i   (clk_raw),
    .clk_gated_o (gated)
  );

  for (genvar g = 0; g < N; g++) begin : g_clk
    logic c;
    int   cnt = 0;
    int   bad = 0;
    real  t_rise = 0.0;
    bit   rise_ok = 1'b0;
    initial begin
      c = 1'b0;
      forever #(3 + g) c = ~c;
    end
    assign clk_raw[g] = c;
    always @(posedge gated[g]) begin
      cnt++;
      t_rise  = $realtime;
      rise_ok = rst_ni;
    end
    always @(negedge gated[g]) begin
      if (rise_ok && rst_ni) begin
        if (($realtime - t_rise) > (3 + g) + 0.01 || ($realtime - t_rise) < (3 + g) - 0.01)
          bad++;
      end
    end
    assign pcnt[g] = cnt;
    assign pbad[g] = bad;
  end

  item_t        exp_q[$];
  bit           busy = 1'b0;
  int           n_tests = 0;
  int           n_fail = 0;
  logic [N-1:0] model;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // monitor: pops expected activity and compares with observed pulses
  initial begin
    item_t it;
    int snap[N];
    logic [N-1:0] act;
    forever begin
      wait (exp_q.size() > 0);
      busy = 1'b1;
      it = exp_q.pop_front();
      #(SETTLE);
      for (int i = 0; i < N; i++) snap[i] = pcnt[i];
      #(WINDOW);
      for (int i = 0; i < N; i++) act[i] = (pcnt[i] != snap[i]);
      n_tests++;
      if (act !== it.v) begin
        n_fail++;
        $display("FAIL %s: active outputs act=%03h exp=%03h", it.tag, act, it.v);
      end
      busy = 1'b0;
    end
  end

  task automatic expect_pat(input logic [N-1:0] v, input string tag);
    item_t it;
    it.v = v;
    it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    wait (!busy);
  endtask

  task automatic shift_bit(input logic b);
    sdata_i = b;
    #(SCLK_PERIOD / 2);
    sclk_i = 1'b1;
    model = {model[N-2:0], b};
    #(SCLK_PERIOD / 2);
    sclk_i = 1'b0;
  endtask

  task automatic load_word(input logic [N-1:0] w, input string tag);
    for (int i = N - 1; i >= 0; i--) shift_bit(w[i]);
    expect_pat(model, tag);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run hung act=timeout exp=done");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b1; sclk_i = 1'b0; sdata_i = 1'b0; model = '1;
    #0.5;
    rst_ni = 1'b0;
    expect_pat('0, "R3");             // reset holds all outputs low
    rst_ni = 1'b1;
    expect_pat('1, "R4");             // all outputs run after release
    load_word(12'h000, "R5");
    load_word(12'hFFF, "R6");
    load_word(12'h001, "R2");         // bit 0 -> output 0
    load_word(12'h800, "R2");         // bit 11 -> output 11
    load_word(12'hFFF, "R6");
    load_word(12'hFFE, "R8");         // only output 0 stops
    load_word(12'hA5A, "R1");
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
    expect_pat(model, "R1");          // partial shift: 12'h2D5
    n_tests++;
    if (model !== 12'h2D5) begin
      n_fail++;
      $display("FAIL R1: shift model act=%03h exp=%03h", model, 12'h2D5);
    end
    load_word(12'h5A5, "R7");
    rst_ni = 1'b0; model = '1;
    expect_pat('0, "R3");
    rst_ni = 1'b1;
    expect_pat('1, "R4");             // reset restored all-ones word
    for (int i = 0; i < N; i++) begin
      n_tests++;
      if (pbad[i] != 0) begin
        n_fail++;
        $display("FAIL R7: output %0d truncated pulses act=%0d exp=0", i, pbad[i]);
      end
    end
    summary();
    $finish;
  end
endmodule